// File: doc/BRIEF.md
# Register-Mapped Factorial Unit

This block is a small compute peripheral behind a 32-bit register port. Software writes an operand into the factorial register. The unit then computes the factorial of that operand one multiply per clock. When it finishes, it writes the product back into the same register. While the unit works, the status register shows it as busy, and any new operand written in that time is discarded.

When a computation ends, busy is cleared. On that same edge the unit can raise a one-cycle completion request toward an external interrupt collector. It does so only when the enable bit in the status register is set. The register space also holds a fixed identification word and a scratch register that returns the bitwise inverse of the last value written to it.

The port is a simple one. A write takes effect on the clock edge where `bus_wr` is high. Read data is a combinational function of the address and the access-size flag. Only full 32-bit accesses are honoured.

Top module: `fact_accel`

## Requirements
- R1: A 32-bit read of offset 0x00 returns 0x010000ED, and writes to that offset change nothing that can be read back.
- R2: A 32-bit read of offset 0x04 returns the bitwise complement of the last 32-bit value written there.
- R3: A 32-bit write to offset 0x08 while idle latches the operand and sets busy (status bit 0) from the next cycle. Reads of 0x08 while busy return that latched operand.
- R4: A write to offset 0x08 while busy is discarded: neither the operand nor the final result is affected.
- R5: When busy falls, offset 0x08 holds n! truncated to 32 bits, with 0! = 1. Busy stays high for exactly n+1 cycles after the starting write.
- R6: The status register at offset 0x20 reads busy in bit 0, the interrupt enable in bit 7 and zero elsewhere. A write copies data bit 7 into the enable and never changes bit 0.
- R7: At completion, `irq_req` is high for exactly one cycle, which is the first cycle in which busy reads 0, and only if the enable was set. Otherwise it stays low.
- R8: Any access with `bus_word` low reads as 0xFFFFFFFF and is ignored on write, at every offset.
- R9: A read of an offset other than 0x00, 0x04, 0x08 or 0x20 returns 0xFFFFFFFF, and a write there is ignored.
- R10: After reset, busy is 0, the enable is 0, offset 0x08 reads 0, offset 0x04 reads 0xFFFFFFFF and `irq_req` is low.
- R11: The multiplier advances one step per clock: while busy and the down-counter is nonzero, the counter drops by exactly one each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_word | input | 1 | 1 = full 32-bit access, 0 = any narrower access |
| bus_addr | input | 8 | Byte offset within the register space |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq_req | output | 1 | One-cycle completion request (interrupt source 0) |

## Verification
Some properties can be checked on every clock, and assertions in the RTL cover them. An operand write while busy must leave the factorial register untouched. A started computation must show busy on the next cycle. The completion request must last a single cycle and never overlap busy. The down-counter must step by exactly one. Other behaviours can only be shown by the bench's scenarios. These are the arithmetic value of the result, including 32-bit truncation for large operands and the 0! case. They also include the exact busy duration, the interaction of the enable bit with completion, the inverted scratch read-back, and the all-ones response to narrow or unmapped accesses.

// File: rtl/fact_pkg.sv
`timescale 1ns/1ps
// Package: shared constants of the factorial unit.
// Holds the register offsets, the identification word and the status bit
// positions. Nothing here is parameter-dependent.
package fact_pkg;
    localparam int unsigned DATA_W  = 32;
    localparam int unsigned ADDR_W  = 8;

    localparam logic [ADDR_W-1:0] OFS_IDENT   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_SCRATCH = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_FACT    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 8'h20;

    localparam logic [DATA_W-1:0] IDENT_WORD  = 32'h010000ED;

    localparam int unsigned STAT_BUSY_BIT = 0;
    localparam int unsigned STAT_IE_BIT   = 7;
endpackage

// File: rtl/fact_engine.sv
`timescale 1ns/1ps
// Module: fact_engine
// Iterative factorial datapath. On start it loads a down-counter with the
// operand and an accumulator with 1. It then multiplies the counter into the
// accumulator once per clock until the counter reaches zero, which takes
// n+1 busy cycles in total.
// Assumes: start is asserted only while idle; the result is truncated to W bits.
module fact_engine #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] operand,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] acc_q;
    logic         busy_q;

    assign busy   = busy_q;
    assign done   = busy_q && (cnt_q == '0);
    assign result = acc_q;

    // Purpose: load on start, multiply-and-decrement while busy, stop at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            acc_q  <= {{(W-1){1'b0}}, 1'b1};
        end else if (start && !busy_q) begin
            busy_q <= 1'b1;
            cnt_q  <= operand;
            acc_q  <= {{(W-1){1'b0}}, 1'b1};
        end else if (busy_q) begin
            if (cnt_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                acc_q <= acc_q * cnt_q;
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R11

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy_q) |=> busy_q); // R3
endmodule

// File: rtl/fact_regs.sv
`timescale 1ns/1ps
// Module: fact_regs
// Register decode for the factorial unit. It holds the scratch word, the
// interrupt enable and the factorial register. That register carries the
// operand while busy and the product afterwards. The module also issues the
// one-cycle completion request.
// Assumes: eng_done is high only while eng_busy is high; reads have no side effects.
module fact_regs
    import fact_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              eng_busy,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_result,
    output logic              eng_start,
    output logic [DATA_W-1:0] eng_operand,
    output logic              irq_req
);
    logic [DATA_W-1:0] scratch_q;
    logic [DATA_W-1:0] fact_q;
    logic              ie_q;
    logic              irq_q;
    logic              wr_ok;

    assign wr_ok       = bus_wr && bus_word;
    assign eng_start   = wr_ok && (bus_addr == OFS_FACT) && !eng_busy;
    assign eng_operand = bus_wdata;
    assign irq_req     = irq_q;

    // Purpose: keep the last scratch write (read back inverted).
    always_ff @(posedge clk) begin
        if (!rst_n)
            scratch_q <= '0;
        else if (wr_ok && bus_addr == OFS_SCRATCH)
            scratch_q <= bus_wdata;
    end

    // Purpose: latch the operand on an accepted start, the product on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fact_q <= '0;
        else if (eng_start)
            fact_q <= bus_wdata;
        else if (eng_done)
            fact_q <= eng_result;
    end

    // Purpose: interrupt enable follows data bit 7 of every status write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ie_q <= 1'b0;
        else if (wr_ok && bus_addr == OFS_STATUS)
            ie_q <= bus_wdata[STAT_IE_BIT];
    end

    // Purpose: one-cycle completion request, gated by the enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= eng_done && ie_q;
    end

    // Purpose: combinational read mux; narrow or unmapped accesses give all ones.
    always_comb begin
        bus_rdata = '1;
        if (bus_word) begin
            case (bus_addr)
                OFS_IDENT:   bus_rdata = IDENT_WORD;
                OFS_SCRATCH: bus_rdata = ~scratch_q;
                OFS_FACT:    bus_rdata = fact_q;
                OFS_STATUS: begin
                    bus_rdata = '0;
                    bus_rdata[STAT_BUSY_BIT] = eng_busy;
                    bus_rdata[STAT_IE_BIT]   = ie_q;
                end
                default:     bus_rdata = '1;
            endcase
        end
    end

    AST_DROP_BUSY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && bus_addr == OFS_FACT && eng_busy && !eng_done) |=> $stable(fact_q)); // R4

    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> !irq_q); // R7

    AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> !eng_busy); // R7

    AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $past(eng_done)); // R7
endmodule

// File: rtl/fact_accel.sv
`timescale 1ns/1ps
// Module: fact_accel (top)
// Register-mapped factorial unit: register decode plus iterative engine.
// Assumes: a single register master; the completion request is collected
// by an external interrupt block.
module fact_accel
    import fact_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_word,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_req
);
    logic              eng_busy;
    logic              eng_done;
    logic              eng_start;
    logic [DATA_W-1:0] eng_result;
    logic [DATA_W-1:0] eng_operand;

    fact_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_wr      (bus_wr),
        .bus_word    (bus_word),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .eng_busy    (eng_busy),
        .eng_done    (eng_done),
        .eng_result  (eng_result),
        .eng_start   (eng_start),
        .eng_operand (eng_operand),
        .irq_req     (irq_req)
    );

    fact_engine #(.W(DATA_W)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .operand (eng_operand),
        .busy    (eng_busy),
        .done    (eng_done),
        .result  (eng_result)
    );
endmodule

// File: tb/fact_accel_bench.sv
`timescale 1ns/1ps
// Bench for fact_accel: directed corner cases plus seeded random operands.
module fact_accel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    fact_accel u_fact_accel (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req)
    );

    function automatic logic [31:0] fact_ref(int n);
        logic [31:0] r = 32'd1;
        for (int i = n; i > 0; i--) r = r * 32'(i);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic w);
        bus_addr = a; bus_wdata = d; bus_word = w; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, input logic w, output logic [31:0] d);
        bus_wr = 1'b0; bus_addr = a; bus_word = w;
        #0.5;
        d = bus_rdata;
        bus_word = 1'b1;
    endtask

    // Start a factorial, then count busy cycles and irq pulses.
    task automatic run_fact(input int n, input logic ie, input string tag);
        logic [31:0] d;
        int k = 0;
        int irq_cnt = 0;
        logic irq_at_fall = 1'b0;
        wr(8'h20, ie ? 32'h80 : 32'h0, 1'b1);
        wr(8'h08, 32'(n), 1'b1);
        rd(8'h08, 1'b1, d);
        chk({tag, " R3 operand while busy"}, d, 32'(n));
        rd(8'h20, 1'b1, d);
        while (d[0] === 1'b1 && k < 100) begin
            if (irq_req) irq_cnt++;
            @(negedge clk);
            k++;
            rd(8'h20, 1'b1, d);
        end
        irq_at_fall = irq_req;
        if (irq_req) irq_cnt++;
        @(negedge clk);
        if (irq_req) irq_cnt++;
        chk({tag, " R5 busy cycles"}, 32'(k), 32'(n + 1));
        chk({tag, " R7 irq at busy fall"}, {31'd0, irq_at_fall}, {31'd0, ie});
        chk({tag, " R7 irq pulse count"}, 32'(irq_cnt), ie ? 32'd1 : 32'd0);
        rd(8'h08, 1'b1, d);
        chk({tag, " R5 result"}, d, fact_ref(n));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] r;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(8'h20, 1'b1, d); chk("R10 status", d, 32'h0);
        rd(8'h08, 1'b1, d); chk("R10 fact", d, 32'h0);
        rd(8'h04, 1'b1, d); chk("R10 scratch", d, 32'hFFFFFFFF);
        chk("R10 irq", {31'd0, irq_req}, 32'd0);

        // R1 identification, write ignored
        rd(8'h00, 1'b1, d); chk("R1 ident", d, 32'h010000ED);
        wr(8'h00, 32'h12345678, 1'b1);
        rd(8'h00, 1'b1, d); chk("R1 ident after write", d, 32'h010000ED);

        // R2 scratch inversion, random values
        for (int i = 0; i < 6; i++) begin
            r = $urandom();
            wr(8'h04, r, 1'b1);
            rd(8'h04, 1'b1, d); chk("R2 scratch", d, ~r);
        end

        // R8 narrow accesses
        rd(8'h00, 1'b0, d); chk("R8 narrow ident", d, 32'hFFFFFFFF);
        wr(8'h04, 32'hA5A5A5A5, 1'b0);
        rd(8'h04, 1'b1, d); chk("R8 narrow scratch write", d, ~r);
        wr(8'h08, 32'd5, 1'b0);
        rd(8'h20, 1'b1, d); chk("R8 narrow fact write no start", d, 32'h0);
        wr(8'h20, 32'h80, 1'b0);
        rd(8'h20, 1'b1, d); chk("R8 narrow status write", d, 32'h0);

        // R9 unmapped
        rd(8'h40, 1'b1, d); chk("R9 unmapped read", d, 32'hFFFFFFFF);
        wr(8'h24, 32'h0, 1'b1);
        rd(8'h24, 1'b1, d); chk("R9 unmapped after write", d, 32'hFFFFFFFF);

        // R6 status bits
        wr(8'h20, 32'hFFFFFFFF, 1'b1);
        rd(8'h20, 1'b1, d); chk("R6 ie set, busy untouched", d, 32'h80);
        wr(8'h20, 32'hFFFFFF7F, 1'b1);
        rd(8'h20, 1'b1, d); chk("R6 ie cleared", d, 32'h0);

        // R5 corner operands
        run_fact(0, 1'b1, "n0");
        run_fact(1, 1'b0, "n1");
        run_fact(12, 1'b1, "n12");
        run_fact(13, 1'b1, "n13 trunc");
        run_fact(34, 1'b0, "n34 trunc");

        // R4 write while busy dropped
        wr(8'h20, 32'h0, 1'b1);
        wr(8'h08, 32'd6, 1'b1);
        wr(8'h08, 32'd3, 1'b1);
        rd(8'h08, 1'b1, d); chk("R4 operand kept", d, 32'd6);
        repeat (10) @(negedge clk);
        rd(8'h08, 1'b1, d); chk("R4 result unaffected", d, 32'd720);
        rd(8'h20, 1'b1, d); chk("R4 idle after", d, 32'h0);

        // R11 R5 R7 random operands and enable
        for (int i = 0; i < 20; i++) begin
            run_fact(int'($urandom_range(0, 40)), logic'($urandom_range(0, 1)), "rand");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule